// File: doc/BRIEF.md
# Operand Address-Mode Decoder

This unit turns the addressing-mode byte of a 16-bit real-mode instruction into the pieces that the rest of the core needs. In memory modes it adds the selected base register, the selected index register and a displacement taken from the instruction stream, giving a 16-bit effective offset. It also says whether the access defaults to the stack segment or the data segment, and how many displacement bytes the instruction used. In register mode it maps the operand field onto a register-file slot. Byte operands map to either the low or the high half of a slot.

The caller presents the mode byte, the current BX, BP, SI and DI values and the two bytes that follow the mode byte in the stream. It also sets two class inputs: one for word or byte operand width, and one for whether the middle field names a segment register. Results appear one clock later, qualified by a valid strobe. Segment override handling and the memory access itself belong to other blocks.

Top module: `amode_ea_unit`

## Requirements
- R1: The mode byte splits into mod = bits 7:6, reg = bits 5:3 and rm = bits 2:0. mod = 3 selects register mode, which reports is_mem = 0, use_ss = 0, disp_len = 0 and ea_offset = 0.
- R2: With mod = 0, rm values 0 to 7 give BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, a direct address, and BX, with disp_len = 0. The direct address (rm = 6) is the 16-bit value {disp_hi, disp_lo} and reports disp_len = 2.
- R3: With mod = 1, disp_lo is sign-extended and added to the rm selection BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP, BX, and disp_len = 1.
- R4: With mod = 2, the 16-bit displacement {disp_hi, disp_lo} (low byte from the first stream byte) is added to the same rm selection as mod = 1, and disp_len = 2.
- R5: use_ss = 1 exactly when a memory mode uses BP as a base: rm = 2 or 3 in any memory mode, or rm = 6 with mod = 1 or 2. Every other case gives use_ss = 0, which means DS.
- R6: All offset arithmetic wraps modulo 2^16.
- R7: When word_op = 1, a register index k (from the rm field in rm_slot/rm_hi, or from the reg field in reg_slot/reg_hi) gives slot k and hi = 0. The slot order is AX=0, CX=1, DX=2, BX=3, SP=4, BP=5, SI=6, DI=7.
- R8: When word_op = 0, index k in 0 to 3 gives slot k with hi = 0 (AL, CL, DL, BL). Index k in 4 to 7 gives slot k-4 with hi = 1 (AH, CH, DH, BH).
- R9: seg_idx equals the reg field bits 1:0, with ES=0, CS=1, SS=2, DS=3. seg_err = 1 exactly when seg_op = 1 and reg bit 2 is set (values 4 to 7).
- R10: Outputs are registered. A byte presented with in_valid = 1 produces its results and out_valid = 1 one clock later. While in_valid = 0, out_valid is 0 and every other output holds its last value.
- R11: While rst is high at a clock edge, out_valid and all result outputs are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs hold a mode byte to decode |
| mode_byte | input | 8 | Addressing-mode byte |
| word_op | input | 1 | 1 = word operands, 0 = byte operands |
| seg_op | input | 1 | Reg field names a segment register |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| disp_lo | input | 8 | First stream byte after the mode byte |
| disp_hi | input | 8 | Second stream byte after the mode byte |
| out_valid | output | 1 | Results below are fresh |
| ea_offset | output | 16 | Effective offset |
| use_ss | output | 1 | Default segment is SS (else DS) |
| is_mem | output | 1 | Memory operand (mod not 3) |
| disp_len | output | 2 | Displacement bytes consumed (0, 1, 2) |
| rm_slot | output | 3 | Register slot named by rm |
| rm_hi | output | 1 | rm names a high byte |
| reg_slot | output | 3 | Register slot named by reg |
| reg_hi | output | 1 | reg names a high byte |
| seg_idx | output | 2 | Segment register index from reg |
| seg_err | output | 1 | Invalid segment register index |

## Verification
The bench targets the irregular entries of the rm table. It checks that mod = 0 with rm = 6 is a direct address that reports two bytes and no stack segment; a design that kept BP there would add BP and flag SS. It feeds negative 8-bit displacements, which a zero-extending design would turn into large positive offsets. It also uses sums that cross 2^16, which a wider adder would leave out of range. The byte-register split into high halves and the segment index range 4 to 7 are checked for both settings of the class inputs. This catches a design that raises the segment error without seg_op, or that maps byte indices as word slots.

// File: rtl/amode_pkg.sv
package amode_pkg;
  typedef enum logic [1:0] {
    MOD_NODISP = 2'd0,
    MOD_DISP8  = 2'd1,
    MOD_DISP16 = 2'd2,
    MOD_REGSEL = 2'd3
  } mod_e;

  typedef struct packed {
    mod_e       md;
    logic [2:0] mid;
    logic [2:0] low;
  } mode_fields_t;

  localparam logic [2:0] RM_DIRECT = 3'd6;
endpackage

// File: rtl/amode_base_sel.sv
module amode_base_sel
  import amode_pkg::*;
#(
  parameter int AW = 16
) (
  input  mod_e          md,
  input  logic [2:0]    rm,
  input  logic [AW-1:0] bx,
  input  logic [AW-1:0] bp,
  input  logic [AW-1:0] si,
  input  logic [AW-1:0] di,
  input  logic [7:0]    d_lo,
  input  logic [7:0]    d_hi,
  output logic [AW-1:0] base_v,
  output logic [AW-1:0] index_v,
  output logic [AW-1:0] disp_v,
  output logic          ss_dflt,
  output logic          mem_op,
  output logic [1:0]    n_disp
);
  logic signed [7:0]  d8;
  logic signed [15:0] d16;
  logic               direct;

  assign d8     = $signed(d_lo);
  assign d16    = $signed({d_hi, d_lo});
  assign direct = (md == MOD_NODISP) && (rm == RM_DIRECT);
  assign mem_op = (md != MOD_REGSEL);

  always_comb begin
    base_v  = '0;
    index_v = '0;
    ss_dflt = 1'b0;
    if (mem_op) begin
      case (rm)
        3'd0: begin base_v = bx; index_v = si; end
        3'd1: begin base_v = bx; index_v = di; end
        3'd2: begin base_v = bp; index_v = si; ss_dflt = 1'b1; end
        3'd3: begin base_v = bp; index_v = di; ss_dflt = 1'b1; end
        3'd4: index_v = si;
        3'd5: index_v = di;
        3'd6: if (!direct) begin base_v = bp; ss_dflt = 1'b1; end
        default: base_v = bx;
      endcase
    end
  end

  always_comb begin
    disp_v = '0;
    n_disp = 2'd0;
    case (md)
      MOD_DISP8: begin
        disp_v = AW'(d8);
        n_disp = 2'd1;
      end
      MOD_DISP16: begin
        disp_v = AW'(d16);
        n_disp = 2'd2;
      end
      MOD_NODISP: if (direct) begin
        disp_v = AW'({d_hi, d_lo});
        n_disp = 2'd2;
      end
      default: begin
        disp_v = '0;
        n_disp = 2'd0;
      end
    endcase
  end
endmodule

// File: rtl/amode_reg_map.sv
module amode_reg_map #(
  parameter int IW = 3
) (
  input  logic [IW-1:0] idx,
  input  logic          wide,
  output logic [IW-1:0] slot,
  output logic          hi_half
);
  localparam int LW = IW - 1;

  always_comb begin
    if (wide) begin
      slot    = idx;
      hi_half = 1'b0;
    end else begin
      slot    = {1'b0, idx[LW-1:0]};
      hi_half = idx[IW-1];
    end
  end
endmodule

// File: rtl/amode_seg_map.sv
module amode_seg_map #(
  parameter int IW = 3
) (
  input  logic [IW-1:0] idx,
  input  logic          is_seg,
  output logic [IW-2:0] seg_sel,
  output logic          bad_idx
);
  assign seg_sel = idx[IW-2:0];
  assign bad_idx = is_seg & idx[IW-1];
endmodule

// File: rtl/amode_ea_unit.sv
module amode_ea_unit
  import amode_pkg::*;
#(
  parameter int AW = 16,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    mode_byte,
  input  logic          word_op,
  input  logic          seg_op,
  input  logic [AW-1:0] reg_bx,
  input  logic [AW-1:0] reg_bp,
  input  logic [AW-1:0] reg_si,
  input  logic [AW-1:0] reg_di,
  input  logic [7:0]    disp_lo,
  input  logic [7:0]    disp_hi,
  output logic          out_valid,
  output logic [AW-1:0] ea_offset,
  output logic          use_ss,
  output logic          is_mem,
  output logic [1:0]    disp_len,
  output logic [IW-1:0] rm_slot,
  output logic          rm_hi,
  output logic [IW-1:0] reg_slot,
  output logic          reg_hi,
  output logic [IW-2:0] seg_idx,
  output logic          seg_err
);
  mode_fields_t f;
  assign f = mode_fields_t'(mode_byte);

  logic [AW-1:0] base_v, index_v, disp_v, sum_v;
  logic          ss_n, mem_n;
  logic [1:0]    nd_n;
  logic [IW-1:0] rms_n, regs_n;
  logic          rmh_n, regh_n;
  logic [IW-2:0] seg_n;
  logic          serr_n;

  amode_base_sel #(.AW(AW)) u_base (
    .md(f.md), .rm(f.low),
    .bx(reg_bx), .bp(reg_bp), .si(reg_si), .di(reg_di),
    .d_lo(disp_lo), .d_hi(disp_hi),
    .base_v(base_v), .index_v(index_v), .disp_v(disp_v),
    .ss_dflt(ss_n), .mem_op(mem_n), .n_disp(nd_n)
  );

  logic [IW-1:0] fld_idx [2];
  logic [IW-1:0] fld_slot [2];
  logic          fld_hi [2];
  assign fld_idx[0] = f.low;
  assign fld_idx[1] = f.mid;

  for (genvar g = 0; g < 2; g++) begin : g_map
    amode_reg_map #(.IW(IW)) u_map (
      .idx(fld_idx[g]), .wide(word_op),
      .slot(fld_slot[g]), .hi_half(fld_hi[g])
    );
  end

  assign rms_n  = fld_slot[0];
  assign rmh_n  = fld_hi[0];
  assign regs_n = fld_slot[1];
  assign regh_n = fld_hi[1];

  amode_seg_map #(.IW(IW)) u_seg (
    .idx(f.mid), .is_seg(seg_op), .seg_sel(seg_n), .bad_idx(serr_n)
  );

  assign sum_v = base_v + index_v + disp_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ea_offset <= '0;
      use_ss    <= 1'b0;
      is_mem    <= 1'b0;
      disp_len  <= 2'd0;
      rm_slot   <= '0;
      rm_hi     <= 1'b0;
      reg_slot  <= '0;
      reg_hi    <= 1'b0;
      seg_idx   <= '0;
      seg_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ea_offset <= sum_v;
        use_ss    <= ss_n;
        is_mem    <= mem_n;
        disp_len  <= nd_n;
        rm_slot   <= rms_n;
        rm_hi     <= rmh_n;
        reg_slot  <= regs_n;
        reg_hi    <= regh_n;
        seg_idx   <= seg_n;
        seg_err   <= serr_n;
      end
    end
  end

  // R1
  regmode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !is_mem) |-> (disp_len == 2'd0 && !use_ss && ea_offset == '0));

  // R5
  ss_needs_mem_chk: assert property (@(posedge clk) disable iff (rst)
    use_ss |-> is_mem);

  // R3
  disp8_len_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_byte[7:6] == 2'b01) |=> (disp_len == 2'd1 && is_mem));

  // R2
  direct_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_byte[7:6] == 2'b00 && mode_byte[2:0] == 3'd6)
      |=> (ea_offset == $past({disp_hi, disp_lo}) && !use_ss && disp_len == 2'd2));

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(ea_offset) && $stable(disp_len)));

  // R9
  seg_err_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !seg_op) |=> !seg_err);
endmodule

// File: tb/amode_ea_unit_bench.sv
module amode_ea_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  mode_byte = '0;
  logic        word_op = 1'b1;
  logic        seg_op = 1'b0;
  logic [15:0] reg_bx = 16'h1234;
  logic [15:0] reg_bp = 16'h8000;
  logic [15:0] reg_si = 16'h0101;
  logic [15:0] reg_di = 16'hFFF0;
  logic [7:0]  disp_lo = '0;
  logic [7:0]  disp_hi = '0;
  logic        out_valid, use_ss, is_mem, rm_hi, reg_hi, seg_err;
  logic [15:0] ea_offset;
  logic [1:0]  disp_len, seg_idx;
  logic [2:0]  rm_slot, reg_slot;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  amode_ea_unit u_amode_ea_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode_byte(mode_byte),
    .word_op(word_op), .seg_op(seg_op),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .disp_lo(disp_lo), .disp_hi(disp_hi),
    .out_valid(out_valid), .ea_offset(ea_offset), .use_ss(use_ss),
    .is_mem(is_mem), .disp_len(disp_len), .rm_slot(rm_slot), .rm_hi(rm_hi),
    .reg_slot(reg_slot), .reg_hi(reg_hi), .seg_idx(seg_idx), .seg_err(seg_err)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int exp_off(input logic [1:0] md, input logic [2:0] r,
                                 input logic [7:0] lo, input logic [7:0] hi);
    int b, d;
    if (md == 2'd3) return 0;
    if (md == 2'd1) d = int'($signed(lo));
    else if (md == 2'd2 || (md == 2'd0 && r == 3'd6)) d = int'({hi, lo});
    else d = 0;
    case (r)
      3'd0: b = reg_bx + reg_si;
      3'd1: b = reg_bx + reg_di;
      3'd2: b = reg_bp + reg_si;
      3'd3: b = reg_bp + reg_di;
      3'd4: b = reg_si;
      3'd5: b = reg_di;
      3'd6: b = (md == 2'd0) ? 0 : int'(reg_bp);
      default: b = reg_bx;
    endcase
    return (b + d) & 32'hFFFF;
  endfunction

  // present one mode byte, then sample one clock later away from the edge
  task automatic apply(input logic [7:0] mb, input logic [7:0] lo, input logic [7:0] hi);
    @(negedge clk);
    mode_byte = mb; disp_lo = lo; disp_hi = hi; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 out_valid", out_valid, 1);
  endtask

  task automatic mem_case(input string tag, input logic [1:0] md, input logic [2:0] r,
                          input logic [7:0] lo, input logic [7:0] hi);
    int len;
    bit ss;
    apply({md, 3'd2, r}, lo, hi);
    len = (md == 2'd1) ? 1 : (md == 2'd2 || (md == 2'd0 && r == 3'd6)) ? 2 : 0;
    ss  = (r == 3'd2 || r == 3'd3 || (r == 3'd6 && md != 2'd0));
    check({tag, " offset"}, ea_offset, exp_off(md, r, lo, hi));
    check({tag, " disp_len"}, disp_len, len);
    check({"R5 use_ss ", tag}, use_ss, ss);
    check({tag, " is_mem"}, is_mem, 1);
  endtask

  task automatic t_reset();
    check("R11 out_valid", out_valid, 0);
    check("R11 ea_offset", ea_offset, 0);
    check("R11 disp_len", disp_len, 0);
    check("R11 seg_err", seg_err, 0);
  endtask

  task automatic t_mod0();
    for (int r = 0; r < 8; r++) mem_case("R2", 2'd0, 3'(r), 8'hA5, 8'h3C);
  endtask

  task automatic t_mod1();
    for (int r = 0; r < 8; r++) mem_case("R3 pos", 2'd1, 3'(r), 8'h12, 8'h77);
    for (int r = 0; r < 8; r++) mem_case("R3 neg", 2'd1, 3'(r), 8'hF0, 8'h77);
    mem_case("R3 min", 2'd1, 3'd4, 8'h80, 8'h00);
  endtask

  task automatic t_mod2();
    for (int r = 0; r < 8; r++) mem_case("R4", 2'd2, 3'(r), 8'h34, 8'h12);
  endtask

  task automatic t_wrap();
    // BP+DI+disp16 = 8000+FFF0+9000 = 20FF0 -> 0FF0
    mem_case("R6 wrap16", 2'd2, 3'd3, 8'h00, 8'h90);
    check("R6 value", ea_offset, 16'h0FF0);
    // DI + (-0x10): FFF0-10 = FFE0
    mem_case("R6 wrap8", 2'd1, 3'd5, 8'hF0, 8'h00);
    check("R6 value8", ea_offset, 16'hFFE0);
  endtask

  task automatic t_regmode();
    word_op = 1'b1;
    for (int k = 0; k < 8; k++) begin
      apply({2'b11, 3'(7 - k), 3'(k)}, 8'hFF, 8'hFF);
      check("R1 is_mem", is_mem, 0);
      check("R1 offset", ea_offset, 0);
      check("R1 disp_len", disp_len, 0);
      check("R1 use_ss", use_ss, 0);
      check("R7 rm_slot", rm_slot, k);
      check("R7 rm_hi", rm_hi, 0);
      check("R7 reg_slot", reg_slot, 7 - k);
      check("R7 reg_hi", reg_hi, 0);
    end
    word_op = 1'b0;
    for (int k = 0; k < 8; k++) begin
      apply({2'b11, 3'(k), 3'(7 - k)}, 8'h00, 8'h00);
      check("R8 rm_slot", rm_slot, (7 - k) % 4);
      check("R8 rm_hi", rm_hi, (7 - k) >= 4);
      check("R8 reg_slot", reg_slot, k % 4);
      check("R8 reg_hi", reg_hi, k >= 4);
    end
    word_op = 1'b1;
  endtask

  task automatic t_seg();
    seg_op = 1'b1;
    for (int k = 0; k < 8; k++) begin
      apply({2'b11, 3'(k), 3'd0}, 8'h00, 8'h00);
      check("R9 seg_idx", seg_idx, k % 4);
      check("R9 seg_err", seg_err, k >= 4);
    end
    seg_op = 1'b0;
    apply({2'b11, 3'd6, 3'd0}, 8'h00, 8'h00);
    check("R9 no seg_op", seg_err, 0);
  endtask

  task automatic t_hold();
    logic [15:0] o;
    logic [1:0]  l;
    mem_case("R10 base", 2'd2, 3'd0, 8'h01, 8'h02);
    o = ea_offset; l = disp_len;
    mode_byte = 8'h46; disp_lo = 8'h55; disp_hi = 8'h66; reg_bx = 16'h0;
    repeat (3) @(negedge clk);
    check("R10 idle valid", out_valid, 0);
    check("R10 hold offset", ea_offset, o);
    check("R10 hold len", disp_len, l);
    reg_bx = 16'h1234;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_mod0();
    t_mod1();
    t_mod2();
    t_wrap();
    t_regmode();
    t_seg();
    t_hold();
    // reset again after activity
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    t_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule